// File: doc/BRIEF.md
# Multi-Mode Operand Fetch and Accumulate Unit

This unit carries out one accumulate-style addition per command: a destination register receives its own value plus an operand. The operand comes from one of ten addressing modes. Two of them take no memory read: a second register, or a sign-extended 16-bit constant. Seven take one word read at an address formed from the constant, a base register and an index register. One, memory indirect, takes two chained reads, the first of which yields the address for the second. Two of the single-read modes also move the base register by one word, before or after the read.

The unit holds a parameterised register file (eight 32-bit registers by default) that clears on reset. A command is taken when `cmd_valid` is high and the unit is idle. Reads go to an external memory port, where a request is held until the port answers with valid. When the sum has been written, `done` pulses and `result` shows the value written. The bench and any host can see a register by sending an immediate-mode command with a zero constant and reading `result`.

The controller is a five-state machine. IDLE accepts a command. Register, immediate and unused codes go to WRITE. Memory modes go to FETCH_A. FETCH_A moves on when valid arrives: to FETCH_B for memory indirect, otherwise to WRITE. FETCH_B goes to WRITE when valid arrives. WRITE always goes to FINISH, and FINISH always returns to IDLE.

Top module: `opacc_unit`

## Requirements
- R1: After reset every register reads zero, and `busy`, `done` and `mem_req` are low.
- R2: Mode 0 (register) adds the register named by `cmd_base` to the destination and makes no memory request.
- R3: Mode 1 (immediate) adds `cmd_imm`, sign-extended from bit 15, to the destination and makes no memory request.
- R4: Mode 2 (displacement) reads at sign-extended constant plus base, and mode 5 (absolute) reads at the sign-extended constant alone. The destination gains the word returned.
- R5: Mode 3 (register indirect) reads at the base register, and mode 4 (indexed) reads at base plus index register. The destination gains the word returned.
- R6: Mode 6 (memory indirect) makes exactly two reads: first at the base register, then at the word that first read returned. The destination gains the second word.
- R7: Mode 7 (auto-increment) reads at the base register's original value, and afterwards the base register holds that value plus 4.
- R8: Mode 8 (auto-decrement) first lowers the base register by 4 and reads at the lowered value, which the base register then holds.
- R9: Mode 9 (scaled) reads at sign-extended constant plus base plus four times the index register.
- R10: `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_valid` high. `done` is high for exactly one cycle, the cycle after the destination write, and `result` then holds the value written.
- R11: While `busy` is high, `cmd_valid` is ignored: no register changes and no extra `done` results from it.
- R12: In modes 7 and 8, when destination and base are the same register, that register ends with the sum, and the base adjustment is dropped.
- R13: Mode codes 10 to 15 change no register and make no memory request. They still pulse `done`, with `result` equal to the destination's unchanged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_mode | input | 4 | Addressing mode code |
| cmd_dst | input | 3 | Destination register |
| cmd_base | input | 3 | Base / source register |
| cmd_idx | input | 3 | Index register |
| cmd_imm | input | 16 | Signed constant or displacement |
| busy | output | 1 | A command is in progress |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Read byte address |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Value written to the destination |

## Verification
The destination write and the base-register adjustment happen in the same WRITE cycle. When an auto-increment or auto-decrement command names the same register as destination and base, both updates target one register. The bench sends such commands for each mode. It then reads the register back through an immediate-mode command with a zero constant and compares it with the sum, with neither base adjustment applied. A second overlap is a new command arriving while a fetch waits on memory. The bench holds `cmd_valid` high during a stretched read and then confirms that only one `done` occurs and that the targeted register is untouched.

// File: rtl/opacc_pkg.sv
package opacc_pkg;
    localparam int OPND_BYTES = 4;
    localparam int SCALE_SH   = $clog2(OPND_BYTES);

    localparam logic [3:0] MD_REG    = 4'd0;
    localparam logic [3:0] MD_IMM    = 4'd1;
    localparam logic [3:0] MD_DISP   = 4'd2;
    localparam logic [3:0] MD_RIND   = 4'd3;
    localparam logic [3:0] MD_INDEX  = 4'd4;
    localparam logic [3:0] MD_ABS    = 4'd5;
    localparam logic [3:0] MD_MIND   = 4'd6;
    localparam logic [3:0] MD_AINC   = 4'd7;
    localparam logic [3:0] MD_ADEC   = 4'd8;
    localparam logic [3:0] MD_SCALED = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_WRITE,
        ST_FINISH
    } state_e;

    function automatic logic mode_reads_mem(input logic [3:0] m);
        return (m >= MD_DISP) && (m <= MD_SCALED);
    endfunction

    function automatic logic mode_is_auto(input logic [3:0] m);
        return (m == MD_AINC) || (m == MD_ADEC);
    endfunction

    function automatic logic mode_is_known(input logic [3:0] m);
        return m <= MD_SCALED;
    endfunction
endpackage

// File: rtl/opacc_regfile.sv
module opacc_regfile #(
    parameter int NREGS = 8,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREGS)-1:0] ra_d,
    input  logic [$clog2(NREGS)-1:0] ra_b,
    input  logic [$clog2(NREGS)-1:0] ra_x,
    output logic [DW-1:0]            rd_d,
    output logic [DW-1:0]            rd_b,
    output logic [DW-1:0]            rd_x,
    input  logic                     we_a,
    input  logic [$clog2(NREGS)-1:0] wa_a,
    input  logic [DW-1:0]            wd_a,
    input  logic                     we_b,
    input  logic [$clog2(NREGS)-1:0] wa_b,
    input  logic [DW-1:0]            wd_b
);
    localparam int RA = $clog2(NREGS);

    logic [DW-1:0] q [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= '0;
            else if (we_a && wa_a == RA'(i))
                r <= wd_a;
            else if (we_b && wa_b == RA'(i))
                r <= wd_b;
        end
        assign q[i] = r;
    end

    assign rd_d = q[ra_d];
    assign rd_b = q[ra_b];
    assign rd_x = q[ra_x];

    // R12: the destination port and the base port never aim at one register together
    assert_no_dual_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && we_b) |-> (wa_a != wa_b));
endmodule

// File: rtl/opacc_agen.sv
module opacc_agen import opacc_pkg::*; #(
    parameter int DW   = 32,
    parameter int IMMW = 16
) (
    input  logic [3:0]      mode,
    input  logic [DW-1:0]   base_v,
    input  logic [DW-1:0]   idx_v,
    input  logic [IMMW-1:0] imm,
    output logic [DW-1:0]   imm_x,
    output logic [DW-1:0]   ea,
    output logic [DW-1:0]   base_upd
);
    localparam logic [DW-1:0] STEP = DW'(OPND_BYTES);

    logic [DW-1:0] scaled;

    always_comb begin
        imm_x  = {{(DW-IMMW){imm[IMMW-1]}}, imm};
        scaled = idx_v << SCALE_SH;
        unique case (mode)
            MD_DISP:   ea = imm_x + base_v;
            MD_INDEX:  ea = base_v + idx_v;
            MD_ABS:    ea = imm_x;
            MD_ADEC:   ea = base_v - STEP;
            MD_SCALED: ea = imm_x + base_v + scaled;
            default:   ea = base_v;
        endcase
        base_upd = (mode == MD_ADEC) ? (base_v - STEP) : (base_v + STEP);
    end
endmodule

// File: rtl/opacc_ctrl.sv
module opacc_ctrl import opacc_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_mode,
    input  logic [3:0] mode_q,
    input  logic       mem_valid,
    output state_e     state,
    output logic       accept,
    output logic       mem_req,
    output logic       second,
    output logic       take,
    output logic       wb,
    output logic       done
);
    state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid) nxt = mode_reads_mem(cmd_mode) ? ST_FETCH_A : ST_WRITE;
            ST_FETCH_A: if (mem_valid) nxt = (mode_q == MD_MIND) ? ST_FETCH_B : ST_WRITE;
            ST_FETCH_B: if (mem_valid) nxt = ST_WRITE;
            ST_WRITE:   nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = (state == ST_IDLE) && cmd_valid;
        mem_req = (state == ST_FETCH_A) || (state == ST_FETCH_B);
        second  = (state == ST_FETCH_B);
        take    = mem_req && mem_valid;
        wb      = (state == ST_WRITE);
        done    = (state == ST_FINISH);
    end

    // R10: a pending read is not withdrawn
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> mem_req);
    // R10: completion is a single-cycle pulse following the write cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wb));
    // R3, R2: register and immediate commands never touch memory
    assert_no_read_regimm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && mode_q <= MD_IMM) |-> !mem_req);
    // R13: unused codes never touch memory
    assert_no_read_unused_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !mode_is_known(mode_q)) |-> !mem_req);
endmodule

// File: rtl/opacc_unit.sv
module opacc_unit import opacc_pkg::*; #(
    parameter int NREGS = 8,
    parameter int DW    = 32,
    parameter int IMMW  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [3:0]               cmd_mode,
    input  logic [$clog2(NREGS)-1:0] cmd_dst,
    input  logic [$clog2(NREGS)-1:0] cmd_base,
    input  logic [$clog2(NREGS)-1:0] cmd_idx,
    input  logic [IMMW-1:0]          cmd_imm,
    output logic                     busy,
    output logic                     mem_req,
    output logic [DW-1:0]            mem_addr,
    input  logic                     mem_valid,
    input  logic [DW-1:0]            mem_rdata,
    output logic                     done,
    output logic [DW-1:0]            result
);
    localparam int RA = $clog2(NREGS);

    state_e          state;
    logic            accept, second, take, wb;
    logic [3:0]      mode_q;
    logic [RA-1:0]   dst_q, base_q, idx_q;
    logic [IMMW-1:0] imm_q;
    logic [DW-1:0]   data_q, res_q;
    logic [DW-1:0]   rd_d, rd_b, rd_x;
    logic [DW-1:0]   imm_x, ea, base_upd;
    logic [DW-1:0]   operand, sum;
    logic            we_a, we_b;

    opacc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_mode  (cmd_mode),
        .mode_q    (mode_q),
        .mem_valid (mem_valid),
        .state     (state),
        .accept    (accept),
        .mem_req   (mem_req),
        .second    (second),
        .take      (take),
        .wb        (wb),
        .done      (done)
    );

    opacc_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_d  (dst_q),
        .ra_b  (base_q),
        .ra_x  (idx_q),
        .rd_d  (rd_d),
        .rd_b  (rd_b),
        .rd_x  (rd_x),
        .we_a  (we_a),
        .wa_a  (dst_q),
        .wd_a  (sum),
        .we_b  (we_b),
        .wa_b  (base_q),
        .wd_b  (base_upd)
    );

    opacc_agen #(.DW(DW), .IMMW(IMMW)) u_agen (
        .mode     (mode_q),
        .base_v   (rd_b),
        .idx_v    (rd_x),
        .imm      (imm_q),
        .imm_x    (imm_x),
        .ea       (ea),
        .base_upd (base_upd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dst_q  <= '0;
            base_q <= '0;
            idx_q  <= '0;
            imm_q  <= '0;
            data_q <= '0;
            res_q  <= '0;
        end else begin
            if (accept) begin
                mode_q <= cmd_mode;
                dst_q  <= cmd_dst;
                base_q <= cmd_base;
                idx_q  <= cmd_idx;
                imm_q  <= cmd_imm;
            end
            if (take)
                data_q <= mem_rdata;
            if (wb)
                res_q <= sum;
        end
    end

    always_comb begin
        if (mode_q == MD_REG)
            operand = rd_b;
        else if (mode_q == MD_IMM)
            operand = imm_x;
        else if (mode_reads_mem(mode_q))
            operand = data_q;
        else
            operand = '0;
        sum  = rd_d + operand;
        we_a = wb && mode_is_known(mode_q);
        we_b = wb && mode_is_auto(mode_q) && (base_q != dst_q);
    end

    assign busy     = (state != ST_IDLE);
    assign mem_addr = second ? data_q : ea;
    assign result   = res_q;

    // R10: address stays put while a read is pending
    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> $stable(mem_addr));
    // R7: base register reads four higher once an auto-increment is finished
    assert_postinc_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MD_AINC && base_q != dst_q) |-> (rd_b == $past(rd_b) + DW'(OPND_BYTES)));
    // R12: shared destination/base ends with the sum
    assert_dest_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_is_auto(mode_q) && base_q == dst_q) |-> (rd_d == result));
    // R11: no new command is latched while busy
    assert_cmd_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(mode_q));
endmodule

// File: tb/opacc_unit_bench.sv
module opacc_unit_bench;
    localparam logic [3:0] M_REG = 4'd0, M_IMM = 4'd1, M_DISP = 4'd2, M_RIND = 4'd3,
                           M_INDEX = 4'd4, M_ABS = 4'd5, M_MIND = 4'd6, M_AINC = 4'd7,
                           M_ADEC = 4'd8, M_SCALED = 4'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_mode = '0;
    logic [2:0]  cmd_dst = '0, cmd_base = '0, cmd_idx = '0;
    logic [15:0] cmd_imm = '0;
    logic        busy, mem_req, done;
    logic [31:0] mem_addr, result;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_vec = 0, n_bad = 0;
    int lat = 0, wcnt = 0, log_n = 0;
    logic [31:0] log_addr [4];
    logic [31:0] sh [8];

    always #5 clk = ~clk;

    opacc_unit u_opacc_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_dst(cmd_dst), .cmd_base(cmd_base), .cmd_idx(cmd_idx), .cmd_imm(cmd_imm),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .result(result)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return a * 32'd3 + 32'h1000_0001;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_valid = 1'b0;
            wcnt = 0;
        end else if (mem_valid) begin
            mem_valid = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = memf(mem_addr);
                if (log_n < 4) log_addr[log_n] = mem_addr;
                log_n++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] m, input logic [2:0] d, input logic [2:0] b,
                       input logic [2:0] x, input logic [15:0] imm, output logic [31:0] res);
        int cyc;
        @(negedge clk);
        log_n = 0;
        cmd_mode = m; cmd_dst = d; cmd_base = b; cmd_idx = x; cmd_imm = imm;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        res = result;
        if (!done) chk(1'b0, "R10 done never seen", 32'd0, 32'd1);
        @(negedge clk);
        chk(!done, "R10 done lasts one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic setr(input int r, input logic [31:0] v);
        logic [31:0] delta, res;
        delta = v - sh[r];
        run(M_IMM, 3'(r), 3'd0, 3'd0, delta[15:0], res);
        sh[r] = v;
    endtask

    task automatic peek(input int r, output logic [31:0] v);
        run(M_IMM, 3'(r), 3'd0, 3'd0, 16'd0, v);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk(!busy && !done && !mem_req, "R1 outputs idle after reset", {29'd0, busy, done, mem_req}, 32'd0);
        for (int r = 0; r < 8; r++) begin
            peek(r, v);
            chk(v == 32'd0, "R1 register clear after reset", v, 32'd0);
        end
    endtask

    task automatic t_reg_imm;
        logic [31:0] res;
        setr(1, 32'd100); setr(2, 32'd23);
        run(M_REG, 3'd1, 3'd2, 3'd0, 16'd0, res);
        chk(res == 32'd123, "R2 register mode sum", res, 32'd123);
        chk(log_n == 0, "R2 no memory read", 32'(log_n), 32'd0);
        sh[1] = 32'd123;
        setr(3, 32'd10);
        run(M_IMM, 3'd3, 3'd0, 3'd0, 16'hFFFB, res);
        chk(res == 32'd5, "R3 immediate sign extended", res, 32'd5);
        chk(log_n == 0, "R3 no memory read", 32'(log_n), 32'd0);
        sh[3] = 32'd5;
    endtask

    task automatic one_read(input string tag, input logic [3:0] m, input logic [2:0] d,
                            input logic [2:0] b, input logic [2:0] x, input logic [15:0] imm,
                            input logic [31:0] exp_addr);
        logic [31:0] res, e;
        e = sh[d] + memf(exp_addr);
        run(m, d, b, x, imm, res);
        chk(log_n == 1 && log_addr[0] == exp_addr, {tag, " read address"}, log_addr[0], exp_addr);
        chk(res == e, {tag, " accumulated sum"}, res, e);
        sh[d] = e;
    endtask

    task automatic t_single;
        setr(2, 32'h200);
        one_read("R4 displacement", M_DISP, 3'd1, 3'd2, 3'd0, 16'hFFF0, 32'h1F0);
        one_read("R4 absolute", M_ABS, 3'd0, 3'd0, 3'd0, 16'h0040, 32'h40);
        one_read("R5 register indirect", M_RIND, 3'd1, 3'd2, 3'd0, 16'h0000, 32'h200);
        setr(3, 32'h30);
        one_read("R5 indexed", M_INDEX, 3'd1, 3'd2, 3'd3, 16'h0000, 32'h230);
        setr(3, 32'd3);
        one_read("R9 scaled", M_SCALED, 3'd0, 3'd2, 3'd3, 16'h0008, 32'h214);
    endtask

    task automatic t_indirect;
        logic [31:0] res, e, p;
        setr(4, 32'h80);
        p = memf(32'h80);
        e = sh[1] + memf(p);
        run(M_MIND, 3'd1, 3'd4, 3'd0, 16'd0, res);
        chk(log_n == 2, "R6 two reads", 32'(log_n), 32'd2);
        chk(log_addr[0] == 32'h80, "R6 first read at base", log_addr[0], 32'h80);
        chk(log_addr[1] == p, "R6 second read at pointer", log_addr[1], p);
        chk(res == e, "R6 sum of pointed word", res, e);
        sh[1] = e;
    endtask

    task automatic t_auto;
        logic [31:0] v;
        setr(5, 32'h300);
        one_read("R7 auto-increment", M_AINC, 3'd1, 3'd5, 3'd0, 16'd0, 32'h300);
        peek(5, v);
        chk(v == 32'h304, "R7 base after increment", v, 32'h304);
        sh[5] = 32'h304;
        setr(6, 32'h400);
        one_read("R8 auto-decrement", M_ADEC, 3'd0, 3'd6, 3'd0, 16'd0, 32'h3FC);
        peek(6, v);
        chk(v == 32'h3FC, "R8 base after decrement", v, 32'h3FC);
        sh[6] = 32'h3FC;
    endtask

    task automatic t_same;
        logic [31:0] v, e;
        setr(5, 32'h300);
        e = 32'h300 + memf(32'h300);
        one_read("R12 auto-increment shared", M_AINC, 3'd5, 3'd5, 3'd0, 16'd0, 32'h300);
        peek(5, v);
        chk(v == e, "R12 sum wins over increment", v, e);
        e = 32'h3FC + memf(32'h3F8);
        one_read("R12 auto-decrement shared", M_ADEC, 3'd6, 3'd6, 3'd0, 16'd0, 32'h3F8);
        peek(6, v);
        chk(v == e, "R12 sum wins over decrement", v, e);
    endtask

    task automatic t_hold_busy;
        logic [31:0] v;
        int ndone;
        setr(7, 32'd5);
        lat = 4;
        ndone = 0;
        @(negedge clk);
        log_n = 0;
        cmd_mode = M_RIND; cmd_dst = 3'd0; cmd_base = 3'd2; cmd_idx = 3'd0; cmd_imm = 16'd0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_mode = M_IMM; cmd_dst = 3'd7; cmd_imm = 16'd100;
        for (int c = 0; c < 3; c++) begin
            chk(busy, "R11 busy during fetch", {31'd0, busy}, 32'd1);
            chk(mem_req && mem_addr == 32'h200, "R10 request held with address", mem_addr, 32'h200);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (done) ndone++;
            @(negedge clk);
        end
        chk(ndone == 1, "R11 single completion", 32'(ndone), 32'd1);
        sh[0] = sh[0] + memf(32'h200);
        lat = 0;
        peek(7, v);
        chk(v == 32'd5, "R11 busy command ignored", v, 32'd5);
    endtask

    task automatic t_unused;
        logic [31:0] res, v;
        run(4'd12, 3'd2, 3'd2, 3'd3, 16'h1234, res);
        chk(res == sh[2], "R13 code 12 result unchanged", res, sh[2]);
        chk(log_n == 0, "R13 code 12 no read", 32'(log_n), 32'd0);
        run(4'd15, 3'd2, 3'd1, 3'd1, 16'h0004, res);
        chk(log_n == 0, "R13 code 15 no read", 32'(log_n), 32'd0);
        peek(2, v);
        chk(v == sh[2], "R13 register untouched", v, sh[2]);
    endtask

    initial begin
        for (int r = 0; r < 8; r++) sh[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_reg_imm;
        t_single;
        t_indirect;
        t_auto;
        t_same;
        t_hold_busy;
        t_unused;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule